// File: doc/BRIEF.md
# I2C Master SCL Pacer

This block sets the clock timing of an I2C bus master. It produces the SCL waveform and tells a byte engine when each bit event is due. SCL low and SCL high are each set by a 10-bit count of peripheral clock cycles. The block then gives the byte engine single-cycle strobes:

- SCL falls.
- SDA may change.
- SCL has really risen on the wire.
- Received data should be sampled.
- A START has finished its hold.
- A STOP has finished its setup.

SDA is driven by the block itself. Between bus events it carries the bit offered by the byte engine.

The SDA change point after each SCL fall is one quarter of the low count. It is taken from bits [9:2] of the effective low width. The programmed high count is meant to be the bit period less the low count and less the bus rise and fall time. Typical low fractions are a little under half the period for 100 kHz and a little over half for 400 kHz. Two rates exist, chosen by a fast-rate select (control bit 7). Each rate has a minimum width that short programmed values are raised to. A separate START enable (control bit 1) gates START generation.

While the generator waits for SCL to go high, the line is read back through a synchronizer. A slave holding SCL low therefore lengthens the high phase. The byte engine may also hold the bus in the low phase with a stall input.

Top module: `i2c_scl_pacer`

## Requirements
- R1: After reset, and whenever no transfer is active, `scl_o` and `sda_o` are both 1, `busy` is 0 and every strobe is 0.
- R2: With `start_ena` = 1, a `start_req` pulse seen in idle drives `sda_o` to 0 with `scl_o` at 1 for exactly H cycles. SCL then falls, with `fall_stb` and `start_stb` in the first low cycle. With `start_ena` = 0, `start_req` has no effect.
- R3: Each SCL low phase lasts exactly L cycles when no stall is applied.
- R4: In the low phase, `upd_stb` pulses in cycle L>>2, counted from the first low cycle as cycle 0. In that same cycle `sda_o` takes the value of `tx_bit`.
- R5: Without stretching, SCL stays released for H + SYNC_STAGES + 1 cycles, and `rise_stb` pulses in cycle SYNC_STAGES + 1 of the release.
- R6: `samp_stb` pulses H>>1 cycles after `rise_stb`, while SCL is still released.
- R7: The effective widths are L = max(`lo_width`, F) and H = max(`hi_width`, F). F is 4 when `fast_sel` = 1 and 8 when `fast_sel` = 0 (defaults of FLOOR_FAST and FLOOR_STD).
- R8: While `scl_in` is held low after release, the high count does not start. Each held cycle moves `rise_stb` and the end of the high phase one cycle later.
- R9: Each cycle `stall` is 1 during a low phase freezes that phase. SCL stays low, and the low phase and the SDA update point both move one cycle later.
- R10: A `stop_req` pulse during a transfer makes the next low phase drive `sda_o` to 0 at its update point. `sda_o` returns to 1, with `stop_stb` pulsing and `busy` falling, H cycles after the following `rise_stb`.
- R11: `en` = 0 returns the block to idle, with `scl_o` = 1, `sda_o` = 1 and `busy` = 0, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; 0 forces idle |
| fast_sel | input | 1 | Rate select (control bit 7): 1 fast, 0 standard |
| start_ena | input | 1 | START generation enable (control bit 1) |
| lo_width | input | 10 | SCL low count in clock cycles |
| hi_width | input | 10 | SCL high count in clock cycles |
| start_req | input | 1 | Request a START from idle |
| stop_req | input | 1 | Request a STOP at the next low phase |
| stall | input | 1 | Byte engine hold; freezes the low phase |
| tx_bit | input | 1 | Bit placed on SDA at the update point |
| scl_in | input | 1 | SCL level read back from the bus |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| busy | output | 1 | A transfer is in progress |
| fall_stb | output | 1 | First cycle of an SCL low phase |
| upd_stb | output | 1 | SDA update point |
| rise_stb | output | 1 | SCL seen high; high count starts |
| samp_stb | output | 1 | Mid-high sample point |
| start_stb | output | 1 | START hold complete |
| stop_stb | output | 1 | STOP complete, bus released |

## Verification
The START hold ends H cycles after the idle edge that accepted the request. The SDA change comes L>>2 cycles into a low phase, plus one cycle for each stalled cycle. The rise strobe follows the release by SYNC_STAGES + 1 cycles plus any cycles the slave holds the line, and the sample strobe comes H>>1 cycles after that. The STOP release comes H cycles after the rise strobe. The bench samples on the falling clock edge and counts cycles from the first low or released cycle of each phase. It records the cycle index at which each strobe appears and compares that index with the value worked out from L and H.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_LOW   = 3'd2,
    PH_RISE  = 3'd3,
    PH_HIGH  = 3'd4
  } phase_e;

  typedef struct packed {
    logic fall;
    logic upd;
    logic rise;
    logic samp;
    logic start;
    logic stop;
  } strobe_t;

endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/scl_width_cfg.sv
module scl_width_cfg #(
  parameter int CNT_W      = 10,
  parameter int FLOOR_STD  = 8,
  parameter int FLOOR_FAST = 4
) (
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] lo_width,
  input  logic [CNT_W-1:0] hi_width,
  output logic [CNT_W-1:0] lo_eff,
  output logic [CNT_W-1:0] hi_eff,
  output logic [CNT_W-1:0] hold_cnt,
  output logic [CNT_W-1:0] half_cnt
);

  localparam logic [CNT_W-1:0] FLR_STD  = CNT_W'(FLOOR_STD);
  localparam logic [CNT_W-1:0] FLR_FAST = CNT_W'(FLOOR_FAST);

  logic [CNT_W-1:0] floor_sel;

  always_comb begin
    floor_sel = fast_sel ? FLR_FAST : FLR_STD;
    lo_eff    = (lo_width < floor_sel) ? floor_sel : lo_width;
    hi_eff    = (hi_width < floor_sel) ? floor_sel : hi_width;
    // SDA change point: one quarter of the low phase
    hold_cnt  = {2'b00, lo_eff[CNT_W-1:2]};
    half_cnt  = {1'b0, hi_eff[CNT_W-1:1]};
  end

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W:0]   cnt_inc
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_we  = clr | adv;
    cnt_d   = clr ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int FLOOR_STD   = 8,
  parameter int FLOOR_FAST  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_sel,
  input  logic             start_ena,
  input  logic [CNT_W-1:0] lo_width,
  input  logic [CNT_W-1:0] hi_width,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             stall,
  input  logic             tx_bit,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             sda_o,
  output logic             busy,
  output logic             fall_stb,
  output logic             upd_stb,
  output logic             rise_stb,
  output logic             samp_stb,
  output logic             start_stb,
  output logic             stop_stb
);

  localparam int RST_STAGES = 2;

  logic             rst_ns;
  logic             scl_seen;
  logic [CNT_W-1:0] lo_eff, hi_eff, hold_cnt, half_cnt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_clr, cnt_adv;

  phase_e  st_q, st_d;
  logic    sda_q, sda_d;
  logic    pend_q, pend_d;
  logic    act_q, act_d;
  strobe_t stb_q, stb_d;

  // reset: asserted asynchronously, released on the clock
  scl_sync_chain #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_ns)
  );

  scl_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk  (clk),
    .rst_n(rst_ns),
    .d    (scl_in),
    .q    (scl_seen)
  );

  scl_width_cfg #(
    .CNT_W(CNT_W), .FLOOR_STD(FLOOR_STD), .FLOOR_FAST(FLOOR_FAST)
  ) u_cfg (
    .fast_sel(fast_sel),
    .lo_width(lo_width),
    .hi_width(hi_width),
    .lo_eff  (lo_eff),
    .hi_eff  (hi_eff),
    .hold_cnt(hold_cnt),
    .half_cnt(half_cnt)
  );

  scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_ns),
    .clr    (cnt_clr),
    .adv    (cnt_adv),
    .cnt_q  (cnt_q),
    .cnt_inc(cnt_inc)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    sda_d   = sda_q;
    pend_d  = pend_q | (stop_req & (st_q != PH_IDLE));
    act_d   = act_q;
    stb_d   = '0;
    cnt_clr = 1'b0;
    cnt_adv = 1'b0;
    if (!en) begin
      st_d    = PH_IDLE;
      sda_d   = 1'b1;
      pend_d  = 1'b0;
      act_d   = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          cnt_clr = 1'b1;
          if (start_req && start_ena) begin
            st_d  = PH_START;
            sda_d = 1'b0;
          end
        end
        PH_START: begin
          if (cnt_inc >= {1'b0, hi_eff}) begin
            st_d        = PH_LOW;
            cnt_clr     = 1'b1;
            stb_d.fall  = 1'b1;
            stb_d.start = 1'b1;
          end else begin
            cnt_adv = 1'b1;
          end
        end
        PH_LOW: begin
          if (!stall) begin
            if (cnt_inc >= {1'b0, lo_eff}) begin
              st_d    = PH_RISE;
              cnt_clr = 1'b1;
            end else begin
              cnt_adv = 1'b1;
              if (cnt_inc == {1'b0, hold_cnt}) begin
                stb_d.upd = 1'b1;
                if (pend_q) begin
                  sda_d  = 1'b0;
                  act_d  = 1'b1;
                  pend_d = 1'b0;
                end else begin
                  sda_d = tx_bit;
                end
              end
            end
          end
        end
        PH_RISE: begin
          if (scl_seen) begin
            st_d       = PH_HIGH;
            cnt_clr    = 1'b1;
            stb_d.rise = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_inc >= {1'b0, hi_eff}) begin
            cnt_clr = 1'b1;
            if (act_q) begin
              st_d       = PH_IDLE;
              sda_d      = 1'b1;
              act_d      = 1'b0;
              stb_d.stop = 1'b1;
            end else begin
              st_d       = PH_LOW;
              stb_d.fall = 1'b1;
            end
          end else begin
            cnt_adv = 1'b1;
            if (cnt_inc == {1'b0, half_cnt}) stb_d.samp = 1'b1;
          end
        end
        default: begin
          st_d    = PH_IDLE;
          sda_d   = 1'b1;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= PH_IDLE;
      sda_q  <= 1'b1;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      stb_q  <= '0;
    end else begin
      st_q   <= st_d;
      sda_q  <= sda_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      stb_q  <= stb_d;
    end
  end

  assign scl_o     = (st_q != PH_LOW);
  assign sda_o     = sda_q;
  assign busy      = (st_q != PH_IDLE);
  assign fall_stb  = stb_q.fall;
  assign upd_stb   = stb_q.upd;
  assign rise_stb  = stb_q.rise;
  assign samp_stb  = stb_q.samp;
  assign start_stb = stb_q.start;
  assign stop_stb  = stb_q.stop;

  // R1: idle bus lines are released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> (scl_o && sda_o));

  // R2: a new transfer begins with SDA low and SCL high
  a_r2_start_shape: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy) |-> (!sda_o && scl_o));

  // R3: the phase count never exceeds the low width
  a_r3_low_bound: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == PH_LOW) |-> ({1'b0, cnt_q} < {1'b0, lo_eff}));

  // R4: SDA update only while SCL is low
  a_r4_upd_low: assert property (@(posedge clk) disable iff (!rst_ns)
    upd_stb |-> !scl_o);

  // R6: sample point only with SCL released and seen high
  a_r6_samp_high: assert property (@(posedge clk) disable iff (!rst_ns)
    samp_stb |-> (scl_o && busy));

  // R8: the high count waits for the line to read back high
  a_r8_wait_line: assert property (@(posedge clk) disable iff (!rst_ns)
    (en && st_q == PH_RISE && !scl_seen) |=> (st_q == PH_RISE && !rise_stb));

  // R9: a stall keeps SCL low
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (en && stall && st_q == PH_LOW) |=> !scl_o);

  // R10: SDA rises under a high SCL only when the transfer ends
  a_r10_stop_only: assert property (@(posedge clk) disable iff (!rst_ns)
    (scl_o && $rose(sda_o)) |-> !busy);

  // R11: disable forces idle
  a_r11_disable: assert property (@(posedge clk) disable iff (!rst_ns)
    !en |=> !busy);

endmodule

// File: tb/i2c_scl_pacer_tb.sv
`timescale 1ns/1ps
module i2c_scl_pacer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       fast_sel = 1'b0;
  logic       start_ena = 1'b0;
  logic [9:0] lo_width = 10'd8;
  logic [9:0] hi_width = 10'd8;
  logic       start_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       stall = 1'b0;
  logic       tx_bit = 1'b1;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       scl_o, sda_o, busy;
  logic       fall_stb, upd_stb, rise_stb, samp_stb, start_stb, stop_stb;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  assign scl_in = scl_o & ~slave_hold;

  i2c_scl_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fast_sel(fast_sel), .start_ena(start_ena),
    .lo_width(lo_width), .hi_width(hi_width), .start_req(start_req),
    .stop_req(stop_req), .stall(stall), .tx_bit(tx_bit), .scl_in(scl_in),
    .scl_o(scl_o), .sda_o(sda_o), .busy(busy), .fall_stb(fall_stb),
    .upd_stb(upd_stb), .rise_stb(rise_stb), .samp_stb(samp_stb),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  // {fast, lo, hi, tx bit, stall cycles, stretch cycles}
  localparam int NVEC = 6;
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 10'd47, 10'd40, 1'b1, 4'd0, 4'd0},
    {1'b1, 10'd26, 10'd20, 1'b0, 4'd0, 4'd0},
    {1'b0, 10'd2,  10'd3,  1'b1, 4'd3, 4'd0},
    {1'b1, 10'd2,  10'd1,  1'b0, 4'd0, 4'd5},
    {1'b0, 10'd13, 10'd9,  1'b1, 4'd2, 4'd4},
    {1'b1, 10'd5,  10'd5,  1'b1, 4'd0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int w, input bit fast);
    int f;
    f = fast ? 4 : 8;
    return (w < f) ? f : w;
  endfunction

  // counts low cycles starting at the first low cycle
  task automatic meas_low(input int stall_k, output int len, output int upd_at);
    len = 0; upd_at = -1;
    while (!scl_o && len < 5000) begin
      if (upd_stb) upd_at = len;
      stall = (len < stall_k);
      len++;
      @(negedge clk);
    end
    stall = 1'b0;
  endtask

  // counts released cycles of a transfer starting at the first released cycle
  task automatic meas_high(input int stretch, input bit do_stop, output int len,
                           output int rise_at, output int samp_at, output int stop_at);
    len = 0; rise_at = -1; samp_at = -1; stop_at = -1;
    while (scl_o && busy && len < 5000) begin
      if (rise_stb) rise_at = len;
      if (samp_stb) samp_at = len;
      slave_hold = (len < stretch);
      stop_req   = do_stop && (len == 0);
      len++;
      @(negedge clk);
    end
    if (stop_stb) stop_at = len;
    slave_hold = 1'b0;
    stop_req   = 1'b0;
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic run_frame(input logic [29:0] v);
    bit fast, bitv;
    int L, H, k, s, n, upd_at, rise_at, samp_at, stop_at;
    fast = v[29]; bitv = v[8];
    k = int'(v[7:4]); s = int'(v[3:0]);
    L = eff(int'(v[28:19]), fast);
    H = eff(int'(v[18:9]), fast);
    fast_sel = fast; lo_width = v[28:19]; hi_width = v[18:9]; tx_bit = bitv;
    start_ena = 1'b1;
    @(negedge clk);
    pulse_start();
    // R2: START hold of H cycles, SDA low
    chk(!sda_o && busy, "R2", "sda low at start", int'(sda_o), 0);
    n = 0;
    while (scl_o && n < 5000) begin n++; @(negedge clk); end
    chk(n == H, "R2", "start hold cycles", n, H);
    chk(fall_stb && start_stb, "R2", "fall/start strobes", int'(fall_stb & start_stb), 1);
    // R3, R4, R9, R7
    meas_low(k, n, upd_at);
    chk(n == L + k, "R3", "low cycles (R7 floor, R9 stall)", n, L + k);
    chk(upd_at == (L >> 2) + k, "R4", "update index", upd_at, (L >> 2) + k);
    chk(sda_o == bitv, "R4", "sda carries tx bit", int'(sda_o), int'(bitv));
    // R5, R6, R8
    meas_high(s, 1'b1, n, rise_at, samp_at, stop_at);
    chk(n == H + 3 + s, "R5", "released cycles (R8 stretch)", n, H + 3 + s);
    chk(rise_at == 3 + s, "R8", "rise strobe index", rise_at, 3 + s);
    chk(samp_at == rise_at + (H >> 1), "R6", "sample index", samp_at, 3 + s + (H >> 1));
    // R10: stop sequence
    meas_low(0, n, upd_at);
    chk(n == L, "R3", "second low cycles", n, L);
    chk(sda_o == 1'b0, "R10", "sda low before stop", int'(sda_o), 0);
    meas_high(0, 1'b0, n, rise_at, samp_at, stop_at);
    chk(n == H + 3, "R10", "stop release cycle", n, H + 3);
    chk(stop_stb == 1'b1, "R10", "stop strobe", int'(stop_stb), 1);
    chk(sda_o && scl_o && !busy, "R10", "bus idle after stop",
        int'({sda_o, scl_o, busy}), 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o && !busy, "R1", "lines during reset",
        int'({scl_o, sda_o, busy}), 6);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_o && sda_o && !busy, "R1", "lines after reset",
        int'({scl_o, sda_o, busy}), 6);
    chk({fall_stb, upd_stb, rise_stb, samp_stb, start_stb, stop_stb} == 6'd0,
        "R1", "strobes idle",
        int'({fall_stb, upd_stb, rise_stb, samp_stb, start_stb, stop_stb}), 0);
    en = 1'b1;
    // R2: start ignored while start generation is disabled
    start_ena = 1'b0;
    @(negedge clk);
    pulse_start();
    n = 0;
    repeat (10) begin
      if (busy || !sda_o || !scl_o) n++;
      @(negedge clk);
    end
    chk(n == 0, "R2", "start ignored when disabled", n, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i]);
      repeat (3) @(negedge clk);
    end

    // R11: disable mid-transfer
    fast_sel = 1'b0; lo_width = 10'd20; hi_width = 10'd20; start_ena = 1'b1;
    pulse_start();
    n = 0;
    while (scl_o && n < 5000) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
    chk(!scl_o && busy, "R11", "in low phase before disable", int'(scl_o), 0);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o && sda_o && !busy, "R11", "idle after disable",
        int'({scl_o, sda_o, busy}), 6);
    en = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy, "R11", "stays idle after re-enable", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule